// File: doc/BRIEF.md
# Serial Flash Boot Image Copier

This block moves a boot image from an SPI serial flash into a parallel SRAM without any help from software. After every reset it reads the flash from byte address zero. It does this with a standard single-lane read: a command byte followed by a three-byte address, then data bytes clocked out back to back. Each byte it receives is written to the SRAM at a base address plus a running index. The SRAM base address and the image length are fixed when the block is built.

While the copy runs, the block holds the system processor in reset. It releases the processor once the last byte is in SRAM. An enable pin is sampled when the block leaves reset: if the pin is low, the flash is not touched and the block reports completion at once. Changing the pin later has no effect until the next reset.

Top module: `flash_boot_copier`

## Requirements
- R1: With enable high at reset release, chip select goes low and the first 32 bits on MOSI are the read command 0x03 followed by the 24-bit address 0x000000, most significant bit first.
- R2: SPI mode 0 is used. SCK idles low, MOSI changes only after a falling SCK edge, MISO is sampled on the rising edge, and each received byte is assembled MSB first.
- R3: Received data byte n (n = 0 .. COPY_LEN-1) is written to SRAM address SRAM_BASE+n with a write strobe one clock cycle wide. Exactly COPY_LEN writes occur per copy.
- R4: Chip select stays low without a break from the first command bit to the last data bit, then returns high. SCK is never high while chip select is high.
- R5: done_o rises after the last SRAM write and stays high until the next reset. The processor reset output cpu_rst_no is low while done_o is low and high once done_o is high.
- R6: With enable low at reset release, chip select never falls, no SRAM write occurs, and done_o is high by the second clock edge after reset release.
- R7: The enable level is taken only at reset release. Changing it while a copy runs does not shorten or change the copy.
- R8: With COPY_LEN = 0, no flash access and no SRAM write occur, and done_o rises as in R6.
- R9: While rst_ni is low: chip select is high, SCK is low, the write strobe is low, done_o is low and cpu_rst_no is low.
- R10: Every reset starts a new, complete copy from flash address zero and SRAM index zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Copy enable, sampled at reset release |
| spi_sck_o | output | 1 | SPI serial clock |
| spi_cs_no | output | 1 | SPI chip select, active low |
| spi_mosi_o | output | 1 | Serial data to the flash |
| spi_miso_i | input | 1 | Serial data from the flash |
| sram_addr_o | output | ADDR_W | SRAM write address |
| sram_data_o | output | 8 | SRAM write data |
| sram_we_o | output | 1 | SRAM write strobe, one cycle per byte |
| done_o | output | 1 | Copy finished or skipped |
| cpu_rst_no | output | 1 | Processor reset, held low until done |

## Verification
The assertions assume two things: the byte shifter is only started while it is idle, and the flash drives MISO in time for the next rising SCK edge. The sequencer guarantees the first, because it issues a new start only one cycle after a byte completes. The bench flash model guarantees the second, because it updates MISO right after each falling SCK edge it sees, which is 1.5 clock cycles before the next rising edge. The stimulus changes enable only when reset is applied, except in one run that changes it on purpose during a copy. Reset is only asserted between runs.

// File: rtl/flash_boot_pkg.sv
package flash_boot_pkg;
  localparam int unsigned HDR_BYTES = 4;
  localparam logic [7:0] READ_CMD = 8'h03;
  localparam logic [23:0] SRC_ADDR = 24'h000000;

  typedef enum logic [1:0] {
    SEQ_START,
    SEQ_XFER,
    SEQ_LAST,
    SEQ_DONE
  } seq_state_e;

  // header byte sent at position idx of the transaction
  function automatic logic [7:0] hdr_byte(input logic [31:0] idx);
    case (idx)
      32'd0:   hdr_byte = READ_CMD;
      32'd1:   hdr_byte = SRC_ADDR[23:16];
      32'd2:   hdr_byte = SRC_ADDR[15:8];
      32'd3:   hdr_byte = SRC_ADDR[7:0];
      default: hdr_byte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/flash_spi_shifter.sv
module flash_spi_shifter #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sck_o,
  output logic       mosi_o,
  output logic       done_o,
  output logic [7:0] rx_o
);
  localparam int unsigned DIV_W = $clog2(HALF_DIV + 1);
  localparam logic [DIV_W-1:0] DIV_END = DIV_W'(HALF_DIV - 1);

  logic             busy_q;
  logic             sck_q;
  logic             smp_q;
  logic             done_q;
  logic [DIV_W-1:0] div_q;
  logic [2:0]       bit_q;
  logic [7:0]       sh_q;
  logic [7:0]       rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      smp_q  <= 1'b0;
      done_q <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          sh_q   <= tx_i;
          div_q  <= '0;
          bit_q  <= '0;
          sck_q  <= 1'b0;
        end
      end else if (div_q == DIV_END) begin
        div_q <= '0;
        if (!sck_q) begin
          sck_q <= 1'b1;
          smp_q <= miso_i;  // sample on rising edge
        end else begin
          sck_q <= 1'b0;
          sh_q  <= {sh_q[6:0], smp_q};  // next MOSI bit after falling edge
          if (bit_q == 3'd7) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            rx_q   <= {sh_q[6:0], smp_q};
          end else begin
            bit_q <= bit_q + 3'd1;
          end
        end
      end else begin
        div_q <= div_q + DIV_W'(1);
      end
    end
  end

  assign sck_o  = sck_q;
  assign mosi_o = sh_q[7];
  assign done_o = done_q;
  assign rx_o   = rx_q;

  p_sck_idle_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !sck_q);
  p_start_only_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
  p_done_after_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $fell(busy_q));
endmodule

// File: rtl/flash_boot_seq.sv
module flash_boot_seq
  import flash_boot_pkg::*;
#(
  parameter int unsigned COPY_LEN = 4096
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enable_i,
  input  logic       byte_done_i,
  output logic       start_o,
  output logic [7:0] tx_o,
  output logic       cs_no,
  output logic       wr_o,
  output logic       done_o
);
  localparam int unsigned TOTAL = COPY_LEN + HDR_BYTES;
  localparam int unsigned CNT_W = $clog2(TOTAL + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TOTAL - 1);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_BYTES);
  localparam bit HAS_DATA = (COPY_LEN != 0);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             start_q;
  logic [7:0]       tx_q;
  logic             cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_START;
      cnt_q   <= '0;
      start_q <= 1'b0;
      tx_q    <= '0;
      cs_q    <= 1'b1;
    end else begin
      start_q <= 1'b0;
      case (state_q)
        SEQ_START: begin
          // enable is taken only here
          if (enable_i && HAS_DATA) begin
            state_q <= SEQ_XFER;
            cs_q    <= 1'b0;
            start_q <= 1'b1;
            tx_q    <= hdr_byte(32'd0);
            cnt_q   <= '0;
          end else begin
            state_q <= SEQ_DONE;
          end
        end
        SEQ_XFER: begin
          if (byte_done_i) begin
            if (cnt_q == CNT_LAST) begin
              state_q <= SEQ_LAST;
              cs_q    <= 1'b1;
            end else begin
              cnt_q   <= cnt_q + CNT_W'(1);
              start_q <= 1'b1;
              tx_q    <= hdr_byte(32'(cnt_q) + 32'd1);
            end
          end
        end
        SEQ_LAST: state_q <= SEQ_DONE;
        default:  state_q <= SEQ_DONE;
      endcase
    end
  end

  assign wr_o    = (state_q == SEQ_XFER) && byte_done_i && (cnt_q >= CNT_HDR);
  assign start_o = start_q;
  assign tx_o    = tx_q;
  assign cs_no   = cs_q;
  assign done_o  = (state_q == SEQ_DONE);

  p_done_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
  p_cs_release_last_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_q) |-> state_q == SEQ_LAST);
  p_no_start_after_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !start_q);
endmodule

// File: rtl/flash_boot_sram_wr.sv
module flash_boot_sram_wr #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned SRAM_BASE = 0,
  parameter int unsigned COPY_LEN  = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [7:0]        data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        data_o,
  output logic              we_o
);
  localparam int unsigned IDX_W = $clog2(COPY_LEN + 2);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(SRAM_BASE);

  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic              we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      we_q   <= 1'b0;
    end else begin
      we_q <= wr_i;
      if (wr_i) begin
        addr_q <= BASE + ADDR_W'(idx_q);
        data_q <= data_i;
        idx_q  <= idx_q + IDX_W'(1);
      end
    end
  end

  assign addr_o = addr_q;
  assign data_o = data_q;
  assign we_o   = we_q;

  p_wr_in_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> idx_q < IDX_W'(COPY_LEN));
  p_we_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |=> !we_q);
endmodule

// File: rtl/flash_boot_copier.sv
module flash_boot_copier #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned SRAM_BASE = 0,
  parameter int unsigned COPY_LEN  = 4096,
  parameter int unsigned HALF_DIV  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  output logic              spi_sck_o,
  output logic              spi_cs_no,
  output logic              spi_mosi_o,
  input  logic              spi_miso_i,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [7:0]        sram_data_o,
  output logic              sram_we_o,
  output logic              done_o,
  output logic              cpu_rst_no
);
  logic       start;
  logic [7:0] tx_byte;
  logic [7:0] rx_byte;
  logic       byte_done;
  logic       wr;
  logic       done;

  flash_boot_seq #(.COPY_LEN(COPY_LEN)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable_i),
    .byte_done_i (byte_done),
    .start_o     (start),
    .tx_o        (tx_byte),
    .cs_no       (spi_cs_no),
    .wr_o        (wr),
    .done_o      (done)
  );

  flash_spi_shifter #(.HALF_DIV(HALF_DIV)) i_shifter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .tx_i    (tx_byte),
    .miso_i  (spi_miso_i),
    .sck_o   (spi_sck_o),
    .mosi_o  (spi_mosi_o),
    .done_o  (byte_done),
    .rx_o    (rx_byte)
  );

  flash_boot_sram_wr #(
    .ADDR_W    (ADDR_W),
    .SRAM_BASE (SRAM_BASE),
    .COPY_LEN  (COPY_LEN)
  ) i_sram_wr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr),
    .data_i (rx_byte),
    .addr_o (sram_addr_o),
    .data_o (sram_data_o),
    .we_o   (sram_we_o)
  );

  assign done_o     = done;
  assign cpu_rst_no = done;

  p_cs_idle_sck_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !spi_sck_o);
  p_no_write_after_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !sram_we_o);
  p_cs_high_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> spi_cs_no);
  p_write_while_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_we_o |-> !done_o && !cpu_rst_no);
endmodule

// File: tb/test_flash_boot_copier.sv
module test_flash_boot_copier;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned BASE   = 16'h0100;
  localparam int unsigned LEN    = 6;

  typedef struct packed {
    logic       en;
    logic [7:0] seed;
    logic       toggle;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{en: 1'b1, seed: 8'h11, toggle: 1'b0},
    '{en: 1'b0, seed: 8'h22, toggle: 1'b0},
    '{en: 1'b1, seed: 8'h5A, toggle: 1'b1},
    '{en: 1'b1, seed: 8'hC3, toggle: 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic miso = 1'b0;
  logic [7:0] seed = 8'h00;

  logic sck, cs_n, mosi, we, done, cpu_rst_n;
  logic [ADDR_W-1:0] addr;
  logic [7:0] wdata;
  logic z_sck, z_cs_n, z_mosi, z_we, z_done, z_cpu_rst_n;
  logic [ADDR_W-1:0] z_addr;
  logic [7:0] z_wdata;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  flash_boot_copier #(.ADDR_W(ADDR_W), .SRAM_BASE(BASE), .COPY_LEN(LEN), .HALF_DIV(2))
  i_flash_boot_copier (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable),
    .spi_sck_o(sck), .spi_cs_no(cs_n), .spi_mosi_o(mosi), .spi_miso_i(miso),
    .sram_addr_o(addr), .sram_data_o(wdata), .sram_we_o(we),
    .done_o(done), .cpu_rst_no(cpu_rst_n)
  );

  flash_boot_copier #(.ADDR_W(ADDR_W), .SRAM_BASE(BASE), .COPY_LEN(0), .HALF_DIV(2))
  i_flash_boot_copier_zero (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(1'b1),
    .spi_sck_o(z_sck), .spi_cs_no(z_cs_n), .spi_mosi_o(z_mosi), .spi_miso_i(1'b0),
    .sram_addr_o(z_addr), .sram_data_o(z_wdata), .sram_we_o(z_we),
    .done_o(z_done), .cpu_rst_no(z_cpu_rst_n)
  );

  function automatic logic [7:0] img(input logic [7:0] s, input int n);
    img = (8'(n) * 8'd29) ^ s ^ 8'h5C;
  endfunction

  // flash model and bus monitor, all at negedge clk
  int wr_cnt, wr_err, cs_falls, rise_cnt, sck_cs_bad, rst_bad, done_fell;
  int z_wr, z_cs_falls;
  logic [31:0] cmd;
  logic prev_sck, prev_cs, prev_done, z_prev_cs;

  always @(negedge clk) begin
    if (!rst_n) begin
      wr_cnt <= 0; wr_err <= 0; cs_falls <= 0; rise_cnt <= 0;
      sck_cs_bad <= 0; rst_bad <= 0; done_fell <= 0; z_wr <= 0; z_cs_falls <= 0;
      cmd <= '0; prev_sck <= 1'b0; prev_cs <= 1'b1; prev_done <= 1'b0;
      z_prev_cs <= 1'b1; miso <= 1'b0;
    end else begin
      if (we) begin
        if (addr != ADDR_W'(BASE + wr_cnt) || wdata != img(seed, wr_cnt)) begin
          wr_err <= wr_err + 1;
          $display("FAIL R3 write %0d: addr %h data %h, expected addr %h data %h",
                   wr_cnt, addr, wdata, ADDR_W'(BASE + wr_cnt), img(seed, wr_cnt));
        end
        wr_cnt <= wr_cnt + 1;
      end
      if (prev_cs && !cs_n) cs_falls <= cs_falls + 1;
      if (!prev_sck && sck && !cs_n) begin
        if (rise_cnt < 32) cmd <= {cmd[30:0], mosi};
        rise_cnt <= rise_cnt + 1;
      end
      if (prev_sck && !sck && rise_cnt >= 32) begin
        automatic int k = rise_cnt - 32;
        automatic logic [7:0] b = img(seed, k / 8);
        miso <= b[7 - (k % 8)];
      end
      if (cs_n && sck) sck_cs_bad <= sck_cs_bad + 1;
      if (cpu_rst_n != done) rst_bad <= rst_bad + 1;
      if (prev_done && !done) done_fell <= done_fell + 1;
      if (z_we) z_wr <= z_wr + 1;
      if (z_prev_cs && !z_cs_n) z_cs_falls <= z_cs_falls + 1;
      prev_sck <= sck; prev_cs <= cs_n; prev_done <= done; z_prev_cs <= z_cs_n;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply_reset(input logic en, input logic [7:0] s);
    @(negedge clk);
    rst_n = 1'b0;
    enable = en;
    seed = s;
    #1;
    // R9: outputs while in reset
    check(cs_n === 1'b1 && sck === 1'b0, "R9 cs/sck", {cs_n, sck}, 2'b10);
    check(we === 1'b0 && done === 1'b0 && cpu_rst_n === 1'b0, "R9 we/done/cpu",
          {we, done, cpu_rst_n}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
  endtask

  initial begin
    int unsigned wd = 0;
    while (wd < 200000) begin @(posedge clk); wd++; end
    $display("FAIL watchdog: run did not end, actual %0d cycles expected fewer", wd);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
    $finish;
  end

  initial begin
    bit ok;
    foreach (VECS[v]) begin
      apply_reset(VECS[v].en, VECS[v].seed);
      if (!VECS[v].en) begin
        // R6: done by second edge after release
        repeat (2) @(negedge clk);
        check(done === 1'b1, "R6 done latency", done, 1);
        repeat (40) @(negedge clk);
        check(cs_falls == 0 && wr_cnt == 0, "R6 no access", cs_falls + wr_cnt, 0);
      end else begin
        if (VECS[v].toggle) begin
          repeat (60) @(negedge clk);
          enable = 1'b0;  // R7: mid-copy change ignored
        end
        wait_done(ok);
        check(ok, "R5 done reached", ok, 1);
        @(negedge clk);
        check(cmd == 32'h0300_0000, "R1 command/address", cmd, 32'h0300_0000);
        check(wr_cnt == LEN, VECS[v].toggle ? "R7 full copy" : "R3 write count",
              wr_cnt, LEN);
        check(wr_err == 0, "R2 data bytes", wr_err, 0);
        check(cs_falls == 1 && cs_n === 1'b1, "R4 single cs window", cs_falls, 1);
        check(rise_cnt == 8 * (LEN + 4), "R2 sck count", rise_cnt, 8 * (LEN + 4));
        if (v == 3) check(wr_cnt == LEN, "R10 repeat copy", wr_cnt, LEN);
      end
      repeat (20) @(negedge clk);
      check(done === 1'b1 && done_fell == 0, "R5 done sticky", done_fell, 0);
      check(rst_bad == 0 && cpu_rst_n === 1'b1, "R5 cpu reset", rst_bad, 0);
      check(sck_cs_bad == 0, "R4 sck while cs high", sck_cs_bad, 0);
      // R8: zero-length instance
      check(z_done === 1'b1 && z_wr == 0 && z_cs_falls == 0, "R8 zero length",
            z_wr + z_cs_falls, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule